// File: doc/BRIEF.md
# Indexed CMOS Configuration Register File

This block is a 64-byte configuration store reached through two byte-wide ports that share one request channel: an index port and a data port. The host first writes a location number to the index port, then reads or writes the selected byte through the data port. The index register is 7 bits wide. Only its low 6 bits select a byte, so locations above 63 alias onto the array. At reset every byte is loaded from a parameter image.

A 16-bit checksum covers the configuration range 0x10 to 0x2C inclusive. Its high byte is held at location 0x2E and its low byte at 0x2F. A sequential engine computes it by adding one byte per clock. The engine runs once, by itself, before the first data-port access after reset is served. It runs again whenever the host pulses the recompute strobe. While the engine runs, the request channel holds ready low. A data-port write that lands in the checksummed range raises a stale flag, and the next recompute clears it.

Top module: `cmos_regfile`

## Requirements
- R1: After reset, `req_ready` is high while no request is pending, `rsp_rdata` is 0x00, `csum_stale` is 0, and the index register reads back 0x00.
- R2: An accepted index-port write (`req_data_sel`=0, `req_write`=1) stores `req_wdata[6:0]` and clears bit 7. An index-port read returns {1'b0, index}. Index-port accesses are never stalled by the first-access checksum.
- R3: Data-port accesses (`req_data_sel`=1) address the byte at index[5:0], so indexes k and k+64 reach the same byte.
- R4: With the default image, byte k after reset is (37*k + 11) mod 256. The only exceptions are 0x2E and 0x2F once the first checksum has run.
- R5: The first data-port request after reset keeps `req_ready` low for exactly 30 cycles (1 start cycle plus 29 summing cycles). It is accepted in the cycle after that.
- R6: The checksum is the 16-bit sum of bytes 0x10 through 0x2C. Its bits [15:8] are written to 0x2E and bits [7:0] to 0x2F.
- R7: An accepted data write whose index[5:0] lies in 0x10..0x2C sets `csum_stale`. Data writes elsewhere leave it unchanged.
- R8: A one-cycle `recalc_req` pulse starts the engine on the next edge. `req_ready` stays low for the following 29 cycles. At the end, 0x2E/0x2F hold the checksum of the current contents and `csum_stale` is 0. Data writes alone never update 0x2E/0x2F.
- R9: Once the first checksum has completed, data-port requests are accepted in the cycle they are presented (ready high), until the next reset.
- R10: A direct data write to 0x2E or 0x2F stores the written byte, and that byte reads back until the next recompute overwrites it.
- R11: `rsp_rdata` changes only on the clock edge that accepts a read, which makes the result visible one cycle after acceptance. It holds its value across idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_sel | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_rdata | output | 8 | Registered read result |
| recalc_req | input | 1 | Pulse to recompute the checksum |
| csum_stale | output | 1 | Checksummed range was written since the last recompute |

## Verification
The timing checks are cycle-exact. Read data is sampled on the falling edge after the accepting rising edge. The stall length is measured in falling edges with ready low, counted from the cycle the request is raised: 30 for the first data access, 29 when a recompute was pulsed one edge earlier, and 0 afterwards. Every stored byte is swept at both its own index and its alias, and compared with a bench model. In that model, the reset image and checksum come from the formula and summation stated in R4 and R6. The stale flag is sampled one cycle after each write. Rewriting the whole checksummed range with an arithmetic pattern is checked against a fresh sum.

// File: rtl/cmos_pkg.sv
// Package: shared constants and the default reset image of the register file.
// Assumes 64 bytes of 8 bits for the default image.
package cmos_pkg;
    localparam int IMG_DEPTH = 64;
    localparam int IMG_W     = 8;

    // Builds the default reset image: byte k = (37*k + 11) mod 256.
    function automatic logic [IMG_DEPTH*IMG_W-1:0] default_image();
        logic [IMG_DEPTH*IMG_W-1:0] img;
        img = '0;
        for (int k = 0; k < IMG_DEPTH; k++) begin
            img[k*IMG_W +: IMG_W] = IMG_W'((k * 37 + 11) % 256);
        end
        return img;
    endfunction
endpackage

// File: rtl/cmos_index_reg.sv
// Module: holds the index register written through the index port.
// Assumes the caller only asserts load on an accepted index write.
// The top bit of the written byte is dropped.
module cmos_index_reg #(
    parameter int IDX_W = 7,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] idx
);
    // Captures the low IDX_W bits of the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (load)  idx <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/cmos_store.sv
// Module: byte array loaded from INIT at reset.
// It has two combinational read ports: one for the bus, one for the checksum engine.
// It has one bus write port and one dual-byte checksum write port.
// Assumes the bus and the checksum writer are never active in the same cycle.
module cmos_store #(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int CK_HI = 46,
    parameter int CK_LO = 47,
    parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ck_we,
    input  logic [2*DW-1:0] ck_val,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] HI_A = AW'(CK_HI);
    localparam logic [AW-1:0] LO_A = AW'(CK_LO);

    logic [DW-1:0] mem [DEPTH];

    // Loads the image at reset; applies bus and checksum writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[i*DW +: DW];
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            if (ck_we) begin
                mem[HI_A] <= ck_val[2*DW-1:DW];
                mem[LO_A] <= ck_val[DW-1:0];
            end
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/cmos_csum_engine.sv
// Module: sequential checksum engine.
// Once started, it walks from FIRST to LAST and adds one byte per clock.
// On the last byte it issues ck_we with the final sum.
// A start while running is ignored.
// Assumes byte_in is the array content at ptr in the same cycle.
module cmos_csum_engine #(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int FIRST = 16,
    parameter int LAST  = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DW-1:0]   byte_in,
    output logic [AW-1:0]   ptr,
    output logic            running,
    output logic            ck_we,
    output logic [2*DW-1:0] ck_val
);
    localparam int CW = 2 * DW;
    localparam logic [AW-1:0] FIRST_A = AW'(FIRST);
    localparam logic [AW-1:0] LAST_A  = AW'(LAST);

    logic [CW-1:0] acc;
    logic [CW-1:0] acc_next;
    logic          last_step;

    // Forms the running sum and flags the final byte.
    always_comb begin
        acc_next  = acc + CW'(byte_in);
        last_step = running && (ptr == LAST_A);
    end

    // Sequences the walk over the summed range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ptr     <= '0;
            acc     <= '0;
        end else if (!running) begin
            if (start) begin
                running <= 1'b1;
                ptr     <= FIRST_A;
                acc     <= '0;
            end
        end else begin
            acc <= acc_next;
            ptr <= ptr + 1'b1;
            if (last_step) running <= 1'b0;
        end
    end

    assign ck_we  = last_step;
    assign ck_val = acc_next;
endmodule

// File: rtl/cmos_regfile.sv
// Module: top of the indexed configuration register file.
// It owns the request handshake, the first-access and recompute triggers, the stale
// flag and the registered read data.
// Assumes one request channel and that the host holds a request until ready is seen.
module cmos_regfile #(
    parameter int IDX_W     = 7,
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int SUM_FIRST = 16,
    parameter int SUM_LAST  = 44,
    parameter int CK_HI     = 46,
    parameter int CK_LO     = 47,
    parameter logic [(1<<AW)*DW-1:0] INIT_IMAGE = cmos_pkg::default_image()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_data_sel,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    input  logic          recalc_req,
    output logic          csum_stale
);
    localparam logic [AW-1:0] FIRST_A = AW'(SUM_FIRST);
    localparam logic [AW-1:0] LAST_A  = AW'(SUM_LAST);

    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    data_addr;
    logic [DW-1:0]    bus_byte;
    logic [DW-1:0]    eng_byte;
    logic [AW-1:0]    eng_ptr;
    logic             running;
    logic             ck_we;
    logic [2*DW-1:0]  ck_val;
    logic             init_done;
    logic             first_hold;
    logic             accept;
    logic             idx_load;
    logic             data_wr;
    logic             eng_start;
    logic             in_range;

    // Derives the handshake and the engine trigger from the request and state.
    always_comb begin
        data_addr  = idx_q[AW-1:0];
        first_hold = req_valid && req_data_sel && !init_done;
        req_ready  = !running && !first_hold;
        accept     = req_valid && req_ready;
        idx_load   = accept && req_write && !req_data_sel;
        data_wr    = accept && req_write && req_data_sel;
        eng_start  = !running && (recalc_req || first_hold);
        in_range   = (data_addr >= FIRST_A) && (data_addr <= LAST_A);
    end

    cmos_index_reg #(.IDX_W(IDX_W), .DW(DW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (idx_load),
        .wdata (req_wdata),
        .idx   (idx_q)
    );

    cmos_store #(.AW(AW), .DW(DW), .CK_HI(CK_HI), .CK_LO(CK_LO), .INIT(INIT_IMAGE)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .wr_addr   (data_addr),
        .wr_data   (req_wdata),
        .ck_we     (ck_we),
        .ck_val    (ck_val),
        .rd_addr_a (data_addr),
        .rd_data_a (bus_byte),
        .rd_addr_b (eng_ptr),
        .rd_data_b (eng_byte)
    );

    cmos_csum_engine #(.AW(AW), .DW(DW), .FIRST(SUM_FIRST), .LAST(SUM_LAST)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .byte_in (eng_byte),
        .ptr     (eng_ptr),
        .running (running),
        .ck_we   (ck_we),
        .ck_val  (ck_val)
    );

    // Records that the first checksum has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)     init_done <= 1'b0;
        else if (ck_we) init_done <= 1'b1;
    end

    // Raises stale on a write into the summed range; a finished recompute clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   csum_stale <= 1'b0;
        else if (ck_we)               csum_stale <= 1'b0;
        else if (data_wr && in_range) csum_stale <= 1'b1;
    end

    // Registers the read result on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_rdata <= '0;
        else if (accept && !req_write)
            rsp_rdata <= req_data_sel ? bus_byte : DW'(idx_q);
    end
endmodule

// File: rtl/cmos_regfile_chk.sv
// Checker: protocol and sequencing properties of cmos_regfile, bound to every instance.
// Assumes the engine walks SPAN bytes per run.
module cmos_regfile_chk #(
    parameter int IDX_W = 7,
    parameter int DW    = 8,
    parameter int SPAN  = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_data_sel,
    input logic [DW-1:0]    req_wdata,
    input logic             req_ready,
    input logic             csum_stale,
    input logic             running,
    input logic             init_done,
    input logic [IDX_W-1:0] idx_q
);
    logic [15:0] run_cnt;

    // Counts consecutive cycles with the engine running.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_cnt <= '0;
        else if (running) run_cnt <= run_cnt + 16'd1;
        else              run_cnt <= '0;
    end

    a_r2_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !req_data_sel) |=> idx_q == $past(req_wdata[IDX_W-1:0]));

    a_r5_no_data_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_data_sel) |-> init_done);

    a_r8_stall_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !req_ready);

    a_r8_stale_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !csum_stale);

    a_r8_run_length_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= 16'(SPAN));

    a_r9_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind cmos_regfile cmos_regfile_chk #(
    .IDX_W (IDX_W),
    .DW    (DW),
    .SPAN  (SUM_LAST - SUM_FIRST + 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_data_sel (req_data_sel),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .csum_stale   (csum_stale),
    .running      (running),
    .init_done    (init_done),
    .idx_q        (idx_q)
);

// File: tb/tb_cmos_regfile.sv
module tb_cmos_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_data_sel = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic [7:0] rsp_rdata;
    logic       recalc_req = 1'b0;
    logic       csum_stale;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int model [64];

    always #2.5 clk = ~clk;

    cmos_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_data_sel(req_data_sel), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .recalc_req(recalc_req), .csum_stale(csum_stale)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Presents one request at a falling edge, counts stall cycles, returns read data.
    task automatic access(input bit sel, input bit wr, input logic [7:0] wd,
                          output logic [7:0] rd, output int waits);
        @(negedge clk);
        req_valid = 1'b1; req_data_sel = sel; req_write = wr; req_wdata = wd;
        waits = 0;
        #0.5;
        while (!req_ready && waits < 1000) begin
            waits++;
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        rd = rsp_rdata;
    endtask

    task automatic pulse_recalc();
        @(negedge clk);
        recalc_req = 1'b1;
        @(posedge clk);
        #1 recalc_req = 1'b0;
    endtask

    function automatic void model_sum();
        int s = 0;
        for (int k = 16; k <= 44; k++) s += model[k];
        model[46] = (s >> 8) & 255;
        model[47] = s & 255;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int w;
        for (int k = 0; k < 64; k++) model[k] = (k * 37 + 11) % 256;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", int'(req_ready), 1);
        check("R1 rdata", int'(rsp_rdata), 0);
        check("R1 stale", int'(csum_stale), 0);
        access(1'b0, 1'b0, 8'h00, rd, w);
        check("R1 index", int'(rd), 0);

        // R2 index capture drops bit 7, no stall before init
        access(1'b0, 1'b1, 8'hC5, rd, w);
        check("R2 idx write waits", w, 0);
        access(1'b0, 1'b0, 8'h00, rd, w);
        check("R2 idx read", int'(rd), 8'h45);
        check("R2 idx read waits", w, 0);

        // R5 first data access stalls 30 cycles; R3 alias 0x45 -> 0x05; R4 image
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R5 first stall", w, 30);
        model_sum();
        check("R3 alias read", int'(rd), model[5]);

        // R9 following accesses not stalled
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R9 no stall", w, 0);

        // R4/R6/R3 sweep every byte at direct and aliased index
        for (int k = 0; k < 64; k++) begin
            access(1'b0, 1'b1, 8'(k), rd, w);
            access(1'b1, 1'b0, 8'h00, rd, w);
            check((k == 46 || k == 47) ? "R6 checksum byte" : "R4 image byte", int'(rd), model[k]);
            access(1'b0, 1'b1, 8'(k + 64), rd, w);
            access(1'b1, 1'b0, 8'h00, rd, w);
            check("R3 aliased byte", int'(rd), model[k]);
        end

        // R7 write outside range leaves stale low
        access(1'b0, 1'b1, 8'h30, rd, w);
        access(1'b1, 1'b1, 8'hA7, rd, w);
        model[48] = 8'hA7;
        check("R7 stale outside", int'(csum_stale), 0);
        // R11 rdata holds across a write
        check("R11 hold on write", int'(rd), model[63]);
        // R7 write inside range (via alias 0x60 -> 0x20) sets stale
        access(1'b0, 1'b1, 8'h60, rd, w);
        access(1'b1, 1'b1, 8'h5A, rd, w);
        model[32] = 8'h5A;
        check("R7 stale inside", int'(csum_stale), 1);
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R3 written byte", int'(rd), 8'h5A);
        // R8 no automatic checksum update
        access(1'b0, 1'b1, 8'h2E, rd, w);
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R8 no auto update", int'(rd), model[46]);
        // R11 hold across idle cycles
        repeat (5) @(negedge clk);
        check("R11 hold idle", int'(rsp_rdata), model[46]);

        // R8 recompute: stall 29, stale cleared, new checksum
        pulse_recalc();
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R8 recompute stall", w, 29);
        model_sum();
        check("R8 stale cleared", int'(csum_stale), 0);
        check("R8 new high byte", int'(rd), model[46]);
        access(1'b0, 1'b1, 8'h2F, rd, w);
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R8 new low byte", int'(rd), model[47]);

        // R10 direct write to checksum byte persists until recompute
        access(1'b1, 1'b1, 8'h11, rd, w);
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R10 direct write", int'(rd), 8'h11);
        pulse_recalc();
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R10 restored by recompute", int'(rd), model[47]);

        // R6/R7/R8 rewrite the whole range with a pattern, then recompute
        for (int k = 16; k <= 44; k++) begin
            access(1'b0, 1'b1, 8'(k), rd, w);
            access(1'b1, 1'b1, 8'((k * 91 + 200) % 256), rd, w);
            model[k] = (k * 91 + 200) % 256;
        end
        check("R7 stale after sweep", int'(csum_stale), 1);
        pulse_recalc();
        access(1'b0, 1'b1, 8'h2E, rd, w);
        check("R8 stall after sweep", w, 29);
        model_sum();
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R6 sweep high byte", int'(rd), model[46]);
        access(1'b0, 1'b1, 8'h2F, rd, w);
        access(1'b1, 1'b0, 8'h00, rd, w);
        check("R6 sweep low byte", int'(rd), model[47]);
        check("R8 stale after sweep recompute", int'(csum_stale), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule